// File: doc/BRIEF.md
# Match Timer with Watchdog Reset

This block holds one 32-bit up-counter and four 32-bit compare channels behind a word-addressed register bus. The counter moves forward only on cycles where an external prescaler asserts a tick strobe, so the same core serves any tick rate (for example 3.6864 MHz or 3.25 MHz). When a tick carries the counter onto a channel's compare value, that channel records an event. The event appears only if the channel's interrupt-enable bit is set. Each channel drives its own interrupt line from its latched event bit. Software clears events by writing ones to the status register.

Compare channel 3 has a second use as a watchdog. If the watchdog-enable bit is armed when channel 3 matches, the block emits a single-cycle system reset pulse and disarms itself. Software keeps the system alive by pushing compare 3 ahead of the counter before it is reached.

Top module: `mtimer_core`

## Requirements
- R1: After reset, the count, all compare values, status, interrupt enables and watchdog enable read as zero, all `irq` lines are low and `sysRstPulse` is low.
- R2: The count rises by exactly one at every clock edge where `tickEn` is high and holds otherwise. It wraps from 0xFFFFFFFF to 0.
- R3: A write to offset 0x10 loads the count, and counting resumes from the loaded value. If a tick arrives in the same cycle, the write wins. Loading the count never produces a match.
- R4: Compare channel i sits at offset 4*i (0x00, 0x04, 0x08, 0x0C). If the enable bit i is set, the clock edge on which a tick moves the count onto compare i sets status bit i and raises `irq[i]`.
- R5: A channel whose enable bit is 0 leaves status bit i at 0 and `irq[i]` low when it matches.
- R6: The status register sits at offset 0x14 and holds bit i for channel i. Writing it clears every bit written as 1 and leaves the others, and each `irq[i]` follows its status bit.
- R7: If a status clear and a new match hit the same channel in the same cycle, the status bit stays set.
- R8: The interrupt-enable register sits at offset 0x1C with bit i for channel i. It keeps only bits 11:0, and higher bits written read back as zero.
- R9: The watchdog enable sits at offset 0x18 and only its bit 0 is kept. If it is 1 when channel 3 matches, `sysRstPulse` is high for exactly the clock cycle after that edge, whatever the interrupt enables say, and the enable then reads 0.
- R10: A channel-3 match with the watchdog enable at 0 gives no reset pulse.
- R11: A read (`busRe`) returns data on `busRdData` after the next clock edge. Any offset outside the eight aligned registers above returns 0 and raises `busErr` for that one cycle. Mapped reads leave `busErr` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count-advance strobe from prescaler |
| busAddr | input | 6 | Byte offset of register access |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |
| busErr | output | 1 | One-cycle flag for an unmapped read |
| irq | output | 4 | Per-channel interrupt lines |
| sysRstPulse | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that `busWe` and `busRe` are never high together and that the bus inputs and `tickEn` hold defined values from time zero. The decode one-hot and the read-error checks depend on this. The stimulus drives every input on the falling edge and starts them all at zero. It issues exactly one bus operation per task, so a read and a write never overlap. The single deliberate overlap of a tick, a status clear and a match is built inside one task so that it is exact to the cycle.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
  localparam int NUM_CH = 4;
  localparam int IDX_W  = $clog2(NUM_CH);

  // Word offsets (byte offset / 4) of the non-compare registers
  localparam int WOFS_COUNT  = 4;
  localparam int WOFS_STATUS = 5;
  localparam int WOFS_WDOG   = 6;
  localparam int WOFS_IEN    = 7;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CMP,
    SEL_COUNT,
    SEL_STATUS,
    SEL_WDOG,
    SEL_IEN
  } rdSel_e;

  typedef struct packed {
    logic [NUM_CH-1:0] wrCmp;
    logic              wrCount;
    logic              wrStatus;
    logic              wrWdog;
    logic              wrIen;
    logic              rdEn;
    rdSel_e            rdSel;
    logic [IDX_W-1:0]  rdIdx;
  } ctrlStrb_t;
endpackage

// File: rtl/mtimer_ctrl.sv
module mtimer_ctrl
  import mtimer_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  output ctrlStrb_t         strb,
  output logic              busErr
);
  localparam int WORD_W = 3;

  logic              aligned;
  logic              inRange;
  logic [WORD_W-1:0] word;
  logic              hit;

  assign aligned = (busAddr[1:0] == 2'b00);
  assign inRange = (busAddr[ADDR_W-1:WORD_W+2] == '0);
  assign word    = busAddr[WORD_W+1:2];

  always_comb begin
    strb       = '0;
    strb.rdSel = SEL_NONE;
    hit        = 1'b0;
    if (aligned && inRange) begin
      if (int'(word) < NUM_CH) begin
        hit                   = 1'b1;
        strb.rdSel            = SEL_CMP;
        strb.rdIdx            = word[IDX_W-1:0];
        strb.wrCmp[word[IDX_W-1:0]] = busWe;
      end else begin
        case (int'(word))
          WOFS_COUNT:  begin hit = 1'b1; strb.rdSel = SEL_COUNT;  strb.wrCount  = busWe; end
          WOFS_STATUS: begin hit = 1'b1; strb.rdSel = SEL_STATUS; strb.wrStatus = busWe; end
          WOFS_WDOG:   begin hit = 1'b1; strb.rdSel = SEL_WDOG;   strb.wrWdog   = busWe; end
          WOFS_IEN:    begin hit = 1'b1; strb.rdSel = SEL_IEN;    strb.wrIen    = busWe; end
          default:     hit = 1'b0;
        endcase
      end
    end
    strb.rdEn = busRe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) busErr <= 1'b0;
    else       busErr <= busRe & ~hit;
  end

  // R11: at most one register is written per access
  p_wr_onehot_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCmp, strb.wrCount, strb.wrStatus, strb.wrWdog, strb.wrIen}));

  // R11: the error flag only follows a read strobe
  p_err_after_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> $past(busRe));
endmodule

// File: rtl/mtimer_dp.sv
module mtimer_dp
  import mtimer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IEN_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  ctrlStrb_t         strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-1:0] irq,
  output logic              sysRstPulse
);
  localparam int WD_CH = NUM_CH - 1;

  logic [DATA_W-1:0] count;
  logic [DATA_W-1:0] cntNext;
  logic [DATA_W-1:0] cmpVal [NUM_CH];
  logic [NUM_CH-1:0] status;
  logic [NUM_CH-1:0] hit;
  logic [IEN_W-1:0]  ien;
  logic              wdEn;

  assign cntNext = count + DATA_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN)             count <= '0;
    else if (strb.wrCount) count <= wrData;
    else if (tickEn)       count <= cntNext;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign hit[i] = tickEn & ~strb.wrCount & (cntNext == cmpVal[i]);

    always_ff @(posedge clk) begin
      if (!rstN)              cmpVal[i] <= '0;
      else if (strb.wrCmp[i]) cmpVal[i] <= wrData;
    end

    always_ff @(posedge clk) begin
      if (!rstN) status[i] <= 1'b0;
      else       status[i] <= (status[i] & ~(strb.wrStatus & wrData[i]))
                            | (hit[i] & ien[i]);
    end

    // R5: an event bit can only appear while its enable was set
    p_status_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
      $rose(status[i]) |-> $past(ien[i]));

    // R6: a clear without a competing match empties the bit
    p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
      (strb.wrStatus && wrData[i] && !hit[i]) |=> !status[i]);
  end

  assign irq = status;

  always_ff @(posedge clk) begin
    if (!rstN)          ien <= '0;
    else if (strb.wrIen) ien <= wrData[IEN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wdEn        <= 1'b0;
      sysRstPulse <= 1'b0;
    end else begin
      sysRstPulse <= wdEn & hit[WD_CH];
      if (wdEn && hit[WD_CH]) wdEn <= 1'b0;
      else if (strb.wrWdog)   wdEn <= wrData[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (strb.rdEn) begin
      case (strb.rdSel)
        SEL_CMP:    rdData <= cmpVal[strb.rdIdx];
        SEL_COUNT:  rdData <= count;
        SEL_STATUS: rdData <= DATA_W'(status);
        SEL_WDOG:   rdData <= DATA_W'(wdEn);
        SEL_IEN:    rdData <= DATA_W'(ien);
        default:    rdData <= '0;
      endcase
    end
  end

  // R2: a tick without a load moves the count by one
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !strb.wrCount) |=> (count == $past(count) + DATA_W'(1)));

  // R2: no tick and no load keeps the count
  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !strb.wrCount) |=> $stable(count));

  // R3: a load takes the written value
  p_count_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCount |=> (count == $past(wrData)));

  // R9: the reset pulse disarms the watchdog and lasts one cycle
  p_wdog_disarm_r9: assert property (@(posedge clk) disable iff (!rstN)
    sysRstPulse |-> !wdEn);
  p_wdog_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    sysRstPulse |=> !sysRstPulse);
endmodule

// File: rtl/mtimer_core.sv
module mtimer_core
  import mtimer_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int IEN_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              busErr,
  output logic [NUM_CH-1:0] irq,
  output logic              sysRstPulse
);
  ctrlStrb_t strb;

  mtimer_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWe   (busWe),
    .busRe   (busRe),
    .strb    (strb),
    .busErr  (busErr)
  );

  mtimer_dp #(.DATA_W(DATA_W), .IEN_W(IEN_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .tickEn      (tickEn),
    .strb        (strb),
    .wrData      (busWrData),
    .rdData      (busRdData),
    .irq         (irq),
    .sysRstPulse (sysRstPulse)
  );
endmodule

// File: tb/mtimer_core_tb_top.sv
module mtimer_core_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic [5:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        busErr;
  logic [3:0]  irq;
  logic        sysRstPulse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mtimer_core dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr),
    .busWe(busWe), .busRe(busRe), .busWrData(busWrData),
    .busRdData(busRdData), .busErr(busErr), .irq(irq),
    .sysRstPulse(sysRstPulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    busAddr = a; busRe = 1'b1;
    @(negedge clk);
    busRe = 1'b0;
    d = busRdData; e = busErr;
  endtask

  task automatic tickOnce();
    @(negedge clk); tickEn = 1'b1;
    @(negedge clk); tickEn = 1'b0;
  endtask

  task automatic readCount(output logic [31:0] c);
    logic e;
    rd(6'h10, c, e);
  endtask

  task automatic t_reset();
    logic [31:0] d; logic e;
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 sysRstPulse", 32'(sysRstPulse), 32'h0);
    for (int a = 0; a < 32; a += 4) begin
      rd(6'(a), d, e);
      chk("R1 register", d, 32'h0);
    end
  endtask

  task automatic t_count();
    logic [31:0] c;
    repeat (5) tickOnce();
    readCount(c);
    chk("R2 five ticks", c, 32'd5);
    repeat (4) @(negedge clk);
    readCount(c);
    chk("R2 hold without tick", c, 32'd5);
    wr(6'h10, 32'hFFFF_FFFE);
    readCount(c);
    chk("R3 load", c, 32'hFFFF_FFFE);
    repeat (3) tickOnce();
    readCount(c);
    chk("R2 wrap", c, 32'h1);
    @(negedge clk);
    tickEn = 1'b1; busAddr = 6'h10; busWrData = 32'h100; busWe = 1'b1;
    @(negedge clk);
    tickEn = 1'b0; busWe = 1'b0;
    readCount(c);
    chk("R3 load beats tick", c, 32'h100);
    tickOnce();
    readCount(c);
    chk("R3 resume after load", c, 32'h101);
  endtask

  task automatic t_match();
    logic [31:0] c, d; logic e;
    wr(6'h1C, 32'hB);
    readCount(c);
    wr(6'h04, c + 3);
    tickOnce(); tickOnce();
    chk("R4 no early irq", 32'(irq), 32'h0);
    tickOnce();
    chk("R4 irq on match", 32'(irq), 32'h2);
    rd(6'h14, d, e);
    chk("R4 status bit1", d, 32'h2);
    readCount(c);
    wr(6'h08, c + 1);
    tickOnce();
    chk("R5 disabled irq", 32'(irq[2]), 32'h0);
    rd(6'h14, d, e);
    chk("R5 disabled status", d & 32'h4, 32'h0);
  endtask

  task automatic t_clear();
    logic [31:0] c, d; logic e;
    readCount(c);
    wr(6'h00, c + 1);
    tickOnce();
    chk("R6 two events", 32'(irq), 32'h3);
    wr(6'h14, 32'h1);
    rd(6'h14, d, e);
    chk("R6 partial clear", d, 32'h2);
    chk("R6 irq follows", 32'(irq), 32'h2);
    wr(6'h14, 32'hFFFF_FFFF);
    chk("R6 full clear", 32'(irq), 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] c, d; logic e;
    readCount(c);
    wr(6'h00, c + 1);
    tickOnce();
    chk("R7 setup", 32'(irq[0]), 32'h1);
    readCount(c);
    wr(6'h00, c + 1);
    @(negedge clk);
    tickEn = 1'b1; busAddr = 6'h14; busWrData = 32'h1; busWe = 1'b1;
    @(negedge clk);
    tickEn = 1'b0; busWe = 1'b0;
    chk("R7 irq kept", 32'(irq[0]), 32'h1);
    rd(6'h14, d, e);
    chk("R7 status kept", d & 32'h1, 32'h1);
    wr(6'h14, 32'hF);
  endtask

  task automatic t_ien();
    logic [31:0] d; logic e;
    wr(6'h1C, 32'hFFFF_FFFF);
    rd(6'h1C, d, e);
    chk("R8 mask", d, 32'h0000_0FFF);
    wr(6'h1C, 32'h3);
    rd(6'h1C, d, e);
    chk("R8 readback", d, 32'h3);
  endtask

  task automatic t_wdog();
    logic [31:0] c, d; logic e;
    wr(6'h18, 32'hFFFF_FFFE);
    rd(6'h18, d, e);
    chk("R9 only bit0", d, 32'h0);
    wr(6'h18, 32'h3);
    rd(6'h18, d, e);
    chk("R9 armed", d, 32'h1);
    readCount(c);
    wr(6'h0C, c + 2);
    tickOnce();
    chk("R9 no early pulse", 32'(sysRstPulse), 32'h0);
    tickOnce();
    chk("R9 pulse", 32'(sysRstPulse), 32'h1);
    @(negedge clk);
    chk("R9 single cycle", 32'(sysRstPulse), 32'h0);
    rd(6'h18, d, e);
    chk("R9 disarmed", d, 32'h0);
    rd(6'h14, d, e);
    chk("R9 status gated", d & 32'h8, 32'h0);
    readCount(c);
    wr(6'h0C, c + 1);
    tickOnce();
    chk("R10 no pulse", 32'(sysRstPulse), 32'h0);
    @(negedge clk);
    chk("R10 still none", 32'(sysRstPulse), 32'h0);
  endtask

  task automatic t_bus();
    logic [31:0] d; logic e;
    rd(6'h24, d, e);
    chk("R11 unmapped data", d, 32'h0);
    chk("R11 unmapped err", 32'(e), 32'h1);
    @(negedge clk);
    chk("R11 err one cycle", 32'(busErr), 32'h0);
    rd(6'h06, d, e);
    chk("R11 misaligned err", 32'(e), 32'h1);
    rd(6'h1C, d, e);
    chk("R11 mapped no err", 32'(e), 32'h0);
    chk("R11 mapped data", d, 32'h3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_match();
    t_clear();
    t_collide();
    t_ien();
    t_wdog();
    t_bus();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule